// File: doc/BRIEF.md
# Slot bitmap transfer list scheduler

This block steps through a buffer of up to 32 transfer descriptor slots, lowest index first, and hands each eligible slot to a transaction engine. Software steers the walk through two 32-bit bitmaps: a skip map, which removes slots from the walk, and a last-slot map, which ends it. The block reports results in a done map, where bit i covers slot i and slot 0 is the first descriptor in the buffer. Software uses a read-only active-slot pointer to tell which slot the engine owns, so that it can avoid writing into that slot.

A start-of-frame pulse begins a walk. For each slot it issues, the block sends the engine a one-cycle start strobe together with the slot index. It then waits for a completion that carries a success flag. When the walk ends, the block pulses a hand-over signal so that the bulk list may run.

Registers are reached through a port of 8-bit command codes. The write code of a register is its read code with bit 7 set. The read data is combinational on the command code.

Top module: `slot_walker`

## Requirements
- R1: After reset, the skip map, last map and done map read 0, the active-slot register reads 32'hFFFF_FFFF, and eng_start and bulk_go are 0.
- R2: A write with code 98h loads the skip map and a write with code 99h loads the last map. Reads with code 18h and 19h return these maps, and code 17h returns the done map. Writes with 9Ah or 97h (the codes of the read-only registers with bit 7 set) change nothing.
- R3: A walk issues slots in strictly ascending index order. A slot whose skip bit is 1 is never issued, and every slot whose skip bit is 0 is issued, up to the end of the walk. The skip map is read live, so a slot whose skip bit was cleared is issued on the next walk.
- R4: Done bit i becomes 1 only on a completion with eng_ok=1 for slot i. A completion with eng_ok=0 leaves the bit at 0, and the walk goes on to the next slot.
- R5: The walk ends at the lowest slot whose last bit is 1, once that slot has been completed or passed over as skipped. bulk_go then goes high for exactly one cycle.
- R6: If no last bit is set at or beyond the current slot, the walk ends after slot 31 and pulses bulk_go.
- R7: A sof pulse that arrives while a walk is running has no effect on the sequence of issued slots.
- R8: Code 1Ah reads 32'hFFFF_FFFF outside a walk. During a walk it reads the zero-extended index of the slot issued most recently, and 0 before the first issue.
- R9: While done_clr is 1, the done map is cleared at the clock edge. A clear takes priority over a set at the same edge.
- R10: eng_start is a one-cycle pulse. No new slot is issued until the completion for the previous one has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Write strobe for the command port |
| cmd_code | input | 8 | Command code (read code, or read code with bit 7 set for a write) |
| cmd_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for cmd_code |
| done_clr | input | 1 | Clears the done map |
| sof | input | 1 | Start-of-frame pulse that begins a walk |
| eng_start | output | 1 | One-cycle issue strobe to the engine |
| eng_slot | output | 5 | Index of the issued slot |
| eng_cpl | input | 1 | Engine completion for the issued slot |
| eng_ok | input | 1 | Success flag sampled with eng_cpl |
| bulk_go | output | 1 | One-cycle pulse: the bulk list may begin |

## Verification
The assertions take for granted that eng_cpl is raised only while a slot is outstanding, so that each issue receives exactly one completion. They also assume that software does not load the skip map while the walk is in the cycle of picking a slot. The stimulus keeps to both. The bench engine answers each eng_start once, after a random delay of zero to three cycles. Map writes happen only between walks. Extra sof pulses are injected only while a slot is outstanding.

// File: rtl/slotw_pkg.sv
package slotw_pkg;
    localparam int unsigned NSLOT  = 32;
    localparam int unsigned IDXW   = $clog2(NSLOT);
    localparam int unsigned WORDW  = 32;

    localparam logic [7:0] RD_DONE = 8'h17;
    localparam logic [7:0] RD_SKIP = 8'h18;
    localparam logic [7:0] RD_LAST = 8'h19;
    localparam logic [7:0] RD_ACT  = 8'h1A;
    localparam logic [7:0] WR_FLAG = 8'h80;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_PICK = 2'd1,
        WS_WAIT = 2'd2
    } walk_state_e;

    typedef struct packed {
        logic            vld;
        logic [IDXW-1:0] idx;
    } slot_ref_t;

    function automatic logic [7:0] wr_code(input logic [7:0] rd);
        return rd | WR_FLAG;
    endfunction
endpackage

// File: rtl/slotw_pick.sv
module slotw_pick
    import slotw_pkg::*;
#(
    parameter int unsigned N  = NSLOT,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  skip,
    input  logic [N-1:0]  last,
    input  logic [IW-1:0] from,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [N-1:0] cand;

    for (genvar g = 0; g < N; g++) begin : g_cand
        assign cand[g] = (g >= int'(from)) && (!skip[g] || last[g]);
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/slotw_regs.sv
module slotw_regs
    import slotw_pkg::*;
#(
    parameter int unsigned N  = NSLOT,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_code,
    input  logic [WORDW-1:0] cmd_wdata,
    output logic [WORDW-1:0] rd_data,
    input  logic          done_clr,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  slot_ref_t     act,
    output logic [N-1:0]  skip_q,
    output logic [N-1:0]  last_q
);
    logic [N-1:0] done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            skip_q <= '0;
            last_q <= '0;
        end else if (cmd_valid) begin
            if (cmd_code == wr_code(RD_SKIP)) skip_q <= cmd_wdata[N-1:0];
            if (cmd_code == wr_code(RD_LAST)) last_q <= cmd_wdata[N-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || done_clr) done_q <= '0;
        else if (set_en)     done_q[set_idx] <= 1'b1;
    end

    always_comb begin
        rd_data = '0;
        unique case (cmd_code)
            RD_SKIP: rd_data[N-1:0] = skip_q;
            RD_LAST: rd_data[N-1:0] = last_q;
            RD_DONE: rd_data[N-1:0] = done_q;
            RD_ACT:  rd_data = act.vld ? WORDW'(act.idx) : '1;
            default: rd_data = '0;
        endcase
    end

    // R4: a done bit only appears after a successful completion
    p_done_only_ok_r4: assert property (@(posedge clk) disable iff (rst)
        ((done_q & ~$past(done_q)) != '0) |-> $past(set_en));
    // R9: clear leaves the map empty
    p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
        $past(done_clr) |-> (done_q == '0));
endmodule

// File: rtl/slotw_scan.sv
module slotw_scan
    import slotw_pkg::*;
#(
    parameter int unsigned N  = NSLOT,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sof,
    input  logic [N-1:0]  skip,
    input  logic [N-1:0]  last,
    input  logic          eng_cpl,
    input  logic          eng_ok,
    output logic          eng_start,
    output logic [IW-1:0] eng_slot,
    output logic          bulk_go,
    output logic          set_en,
    output logic [IW-1:0] set_idx,
    output slot_ref_t     act
);
    walk_state_e   st;
    logic [IW-1:0] cur;
    logic          cur_last;
    logic          found;
    logic [IW-1:0] pick;

    slotw_pick #(.N(N)) i_pick (
        .skip (skip),
        .last (last),
        .from (cur),
        .found(found),
        .idx  (pick)
    );

    assign set_en  = (st == WS_WAIT) && eng_cpl && eng_ok;
    assign set_idx = eng_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= WS_IDLE;
            cur       <= '0;
            cur_last  <= 1'b0;
            eng_start <= 1'b0;
            eng_slot  <= '0;
            bulk_go   <= 1'b0;
            act       <= '{vld: 1'b0, idx: '0};
        end else begin
            eng_start <= 1'b0;
            bulk_go   <= 1'b0;
            unique case (st)
                WS_IDLE: if (sof) begin
                    st  <= WS_PICK;
                    cur <= '0;
                    act <= '{vld: 1'b1, idx: '0};
                end
                WS_PICK: begin
                    if (!found || skip[pick]) begin
                        st      <= WS_IDLE;
                        bulk_go <= 1'b1;
                        act.vld <= 1'b0;
                    end else begin
                        eng_start <= 1'b1;
                        eng_slot  <= pick;
                        cur_last  <= last[pick];
                        act.idx   <= pick;
                        st        <= WS_WAIT;
                    end
                end
                WS_WAIT: if (eng_cpl) begin
                    if (cur_last || eng_slot == IW'(N - 1)) begin
                        st      <= WS_IDLE;
                        bulk_go <= 1'b1;
                        act.vld <= 1'b0;
                    end else begin
                        cur <= eng_slot + 1'b1;
                        st  <= WS_PICK;
                    end
                end
                default: st <= WS_IDLE;
            endcase
        end
    end

    // R3: an issued slot had its skip bit clear when it was chosen
    p_no_skipped_issue_r3: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> ((($past(skip) >> eng_slot) & 1) == 0));
    // R10: issue strobe lasts one cycle
    p_single_issue_r10: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);
    // R5: hand-over is a single-cycle pulse
    p_bulk_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        bulk_go |=> !bulk_go);
    // R10: no issue and hand-over together
    p_issue_vs_bulk_r10: assert property (@(posedge clk) disable iff (rst)
        !(eng_start && bulk_go));
endmodule

// File: rtl/slot_walker.sv
module slot_walker
    import slotw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [7:0]  cmd_code,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] rd_data,
    input  logic        done_clr,
    input  logic        sof,
    output logic        eng_start,
    output logic [4:0]  eng_slot,
    input  logic        eng_cpl,
    input  logic        eng_ok,
    output logic        bulk_go
);
    logic [NSLOT-1:0] skip_q;
    logic [NSLOT-1:0] last_q;
    logic             set_en;
    logic [IDXW-1:0]  set_idx;
    slot_ref_t        act;

    slotw_regs #(.N(NSLOT)) i_regs (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_wdata(cmd_wdata),
        .rd_data(rd_data), .done_clr(done_clr),
        .set_en(set_en), .set_idx(set_idx), .act(act),
        .skip_q(skip_q), .last_q(last_q)
    );

    slotw_scan #(.N(NSLOT)) i_scan (
        .clk(clk), .rst(rst), .sof(sof),
        .skip(skip_q), .last(last_q),
        .eng_cpl(eng_cpl), .eng_ok(eng_ok),
        .eng_start(eng_start), .eng_slot(eng_slot), .bulk_go(bulk_go),
        .set_en(set_en), .set_idx(set_idx), .act(act)
    );

    // R8: the pointer is released when the walk ends
    p_act_idle_r8: assert property (@(posedge clk) disable iff (rst)
        bulk_go |-> !act.vld);
endmodule

// File: tb/test_slot_walker.sv
module test_slot_walker;
    localparam int CLK_T = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = 8'h1A;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] rd_data;
    logic        done_clr = 1'b0;
    logic        sof = 1'b0;
    logic        eng_start;
    logic [4:0]  eng_slot;
    logic        eng_cpl = 1'b0;
    logic        eng_ok = 1'b0;
    logic        bulk_go;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    slot_walker i_slot_walker (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_wdata(cmd_wdata), .rd_data(rd_data), .done_clr(done_clr),
        .sof(sof), .eng_start(eng_start), .eng_slot(eng_slot),
        .eng_cpl(eng_cpl), .eng_ok(eng_ok), .bulk_go(bulk_go)
    );

    always #(CLK_T/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] code, output logic [31:0] v);
        cmd_code = code;
        #1 v = rd_data;
    endtask

    task automatic wr(input logic [7:0] code, input logic [31:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = 8'h1A;
    endtask

    // expected issue order from the requirements (R3, R5, R6)
    function automatic int exp_list(input logic [31:0] sk, input logic [31:0] ls,
                                    output int lst[32]);
        int n = 0;
        for (int i = 0; i < 32; i++) begin
            if (sk[i] && ls[i]) break;
            if (!sk[i]) begin lst[n] = i; n++; end
            if (ls[i]) break;
        end
        return n;
    endfunction

    task automatic run_walk(input logic [31:0] sk, input logic [31:0] ls,
                            input logic [31:0] okm, input bit clr_first, input bit extra_sof);
        int lst[32];
        int n, k, guard;
        logic [31:0] v, exp_done;
        bit got;
        n = exp_list(sk, ls, lst);
        wr(8'h98, sk);
        wr(8'h99, ls);
        @(negedge clk); done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
        rd(8'h17, v); chk("R9 clear", v, 32'h0);
        exp_done = '0;
        sof = 1'b1; @(negedge clk); sof = 1'b0;
        k = 0; got = 0; guard = 0;
        while (!got && guard < 2000) begin
            guard++;
            if (eng_start) begin
                chk("R3 order", {27'd0, eng_slot}, (k < n) ? lst[k] : 32'hDEAD);
                rd(8'h1A, v); chk("R8 active", v, {27'd0, eng_slot});
                if (extra_sof) begin sof = 1'b1; @(negedge clk); sof = 1'b0; end
                for (int d = $urandom_range(0, 3); d > 0; d--) @(negedge clk);
                rd(8'h1A, v); chk("R10 held", v, {27'd0, eng_slot});
                eng_cpl = 1'b1; eng_ok = okm[eng_slot];
                if (clr_first && k == 0) begin
                    done_clr = 1'b1; exp_done = '0;
                end else if (okm[eng_slot]) exp_done[eng_slot] = 1'b1;
                @(negedge clk);
                eng_cpl = 1'b0; eng_ok = 1'b0; done_clr = 1'b0;
                k++;
            end else if (bulk_go) begin
                got = 1;
                @(negedge clk);
                chk("R5 pulse", {31'd0, bulk_go}, 32'd0);
            end else @(negedge clk);
        end
        chk("R5/R6 bulk_go", {31'd0, got}, 32'd1);
        chk("R3 count", k, n);
        rd(8'h17, v); chk("R4 done", v, exp_done);
        rd(8'h1A, v); chk("R8 idle", v, 32'hFFFF_FFFF);
    endtask

    initial begin
        logic [31:0] v, sk, ls;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(8'h18, v); chk("R1 skip", v, 0);
        rd(8'h19, v); chk("R1 last", v, 0);
        rd(8'h17, v); chk("R1 done", v, 0);
        rd(8'h1A, v); chk("R1 active", v, 32'hFFFF_FFFF);
        chk("R1 strobes", {30'd0, eng_start, bulk_go}, 0);

        wr(8'h98, 32'hA5A5_0F0F); rd(8'h18, v); chk("R2 skip", v, 32'hA5A5_0F0F);
        wr(8'h99, 32'h1234_8001); rd(8'h19, v); chk("R2 last", v, 32'h1234_8001);
        wr(8'h9A, 32'h0000_0003); rd(8'h1A, v); chk("R2 ro active", v, 32'hFFFF_FFFF);
        wr(8'h97, 32'hFFFF_FFFF); rd(8'h17, v); chk("R2 ro done", v, 0);
        rd(8'h18, v); chk("R2 skip kept", v, 32'hA5A5_0F0F);

        // R6: no last bit, every slot, all succeed
        run_walk(32'h0, 32'h0, 32'hFFFF_FFFF, 0, 0);
        // R4: failures leave bits clear and walk continues
        run_walk(32'h0000_00F0, 32'h0000_0400, 32'h0000_0205, 0, 0);
        // R5: last on a skipped slot ends walk there
        run_walk(32'h0000_0010, 32'h0000_0010, 32'hFFFF_FFFF, 0, 0);
        // R3: skip cleared then processed next walk
        run_walk(32'hFFFF_FFFE, 32'h0, 32'h1, 0, 0);
        run_walk(32'hFFFF_FFFC, 32'h0, 32'h3, 0, 0);
        // R9: clear coincident with first successful completion
        run_walk(32'hFFFF_FF00, 32'h0000_0800, 32'hFFFF_FFFF, 1, 0);
        // R7: sof during walk ignored
        run_walk(32'hFFFF_0000, 32'h8000_0000, 32'hFFFF_FFFF, 0, 1);
        // all skipped
        run_walk(32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 0, 0);

        for (int r = 0; r < 14; r++) begin
            sk = $urandom;
            ls = ($urandom_range(0, 2) == 0) ? 32'h0 : (32'h1 << $urandom_range(0, 31));
            run_walk(sk, ls, $urandom, 0, (r % 3) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule